// File: doc/BRIEF.md
# Multi-Mode Timer Counter Channel

This block is one channel of an interval timer. It holds a 16-bit down counter that advances only in system-clock cycles where the count-clock enable is high. A gate input and a single output pin go with it. Software writes a mode code and a BCD flag, then writes a count value. From then on the channel produces one of six output behaviours:

- an interrupt-style level at terminal count;
- a gate-triggered, retriggerable one-shot;
- a periodic rate pulse;
- a square wave;
- a strobe triggered by the count write;
- a strobe triggered by a gate edge.

The live count is always visible on `count_o`, so a register layer outside the block can latch it.

The counter decrements either as a plain binary word or as four BCD decades. A loaded value of zero stands for the largest count: 65536 in binary or 10000 in BCD. A rising edge on the gate is captured on the system clock and held until the next count tick. This lets slow gate signals and sparse count enables work together without missing a trigger.

Top module: `pit_chan`

## Requirements
- R1: After reset `out_o` is low and `count_o` is 0, and the channel stays idle until a count is written.
- R2: Mode code 0 drives `out_o` low. The first tick after a count write loads N. Each later tick with the gate high decrements. `out_o` rises on the tick that reaches 0 and stays high until the next count write.
- R3: In mode code 1, `out_o` idles high. The first tick after a gate rising edge loads N and drives `out_o` low. `out_o` returns high on the N-th following tick. A new gate rising edge during the count reloads N.
- R4: In mode code 2, once started, `out_o` is high for N-1 ticks and low for 1 tick in every period of N ticks, with automatic reload.
- R5: In mode code 3, `out_o` is high for ceil(N/2) ticks and low for floor(N/2) ticks, repeating continuously.
- R6: In mode code 4, the first tick after a count write loads N, with `out_o` high. `out_o` drops low on the tick that reaches 0 and goes high again on the next tick.
- R7: In mode code 5, `out_o` idles high. The first tick after a gate rising edge loads N. `out_o` is low for exactly one tick after the count reaches 0.
- R8: With the BCD flag set, each of the four 4-bit digits of `count_o` stays within 0 to 9. A decrement borrows digit by digit, so 0x1000 becomes 0x0999 and 0x0000 becomes 0x9999.
- R9: A loaded count of 0 behaves as 65536 in binary and as 10000 in BCD.
- R10: In modes 0, 2, 3 and 4, gate low suspends decrementing. In modes 2 and 3, gate low also forces `out_o` high from the next cycle. The first tick after a gate rising edge reloads N.
- R11: A mode write returns the channel to idle and clears the count to 0. It sets `out_o` low for code 0 and high for any other code. Codes 6 and 7 act as 2 and 3. A count write in the same cycle as a mode write is ignored.
- R12: `count_o` changes only in cycles with `cnt_en_i` high. In modes 1 and 5, `out_o` also changes only in such cycles. Mode writes are the exception to both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-clock enable; one tick per high cycle |
| gate_i | input | 1 | Gate input |
| mode_wr_i | input | 1 | Mode and BCD flag write strobe |
| mode_i | input | 3 | Mode code 0 to 7 |
| bcd_i | input | 1 | 1 selects BCD counting, 0 selects binary |
| load_i | input | 1 | Count value write strobe |
| count_i | input | 16 | Count value N |
| count_o | output | 16 | Live counter value |
| out_o | output | 1 | Channel output |

## Verification
The bench measures square-wave half periods for both odd and even N. A design that splits odd counts evenly, or that reloads N instead of N-1 for the low half, gives the wrong low-phase length.

BCD runs cross a decade boundary and start from zero. A design that borrows in binary would show 0x0FFF or 0xFFFF instead of 0x0999 or 0x9999.

A full 65536-tick strobe run checks the zero-means-maximum rule. A design that stops at the first zero would strobe one tick after loading.

Gate suspension, the rate output forced high while the gate is low, and one-shot retrigger are each driven mid-count. A design that ignores the gate, keeps a low pulse, or ignores the second trigger fails the count or output check that follows.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_TC_IRQ  = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SW_STB  = 3'd4,
    MD_HW_STB  = 3'd5
  } pit_mode_e;

  // codes 6/7 alias the periodic modes
  function automatic pit_mode_e decode_mode(input logic [MODE_W-1:0] code);
    if (code[1]) return pit_mode_e'({1'b0, code[1:0]});
    return pit_mode_e'(code);
  endfunction
endpackage

// File: rtl/pit_dec.sv
module pit_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         bcd_i,
  output logic [W-1:0] val_o
);
  localparam int ND = W / 4;

  logic [ND-1:0] brw;
  logic [W-1:0]  bcd_v;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < ND; g++) begin : g_dig
    logic [3:0] d;
    assign d = val_i[4*g +: 4];
    assign bcd_v[4*g +: 4] = !brw[g] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (g < ND - 1) begin : g_brw
      assign brw[g+1] = brw[g] & (d == 4'd0);
    end
  end

  assign val_o = bcd_i ? bcd_v : val_i - W'(1);
endmodule

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/pit_chan_ctrl.sv
module pit_chan_ctrl
  import pit_chan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              gate_rise_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              bcd_i,
  input  logic              load_i,
  input  logic [W-1:0]      count_i,
  output logic [W-1:0]      cnt_o,
  output logic              out_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  pit_mode_e   mode_q, mode_new;
  logic [W-1:0] cnt_q, reload_q, dec1, dec2;
  logic bcd_q, out_q, loaded_q, st_pend_q, run_q, trig_q, strobe_q;
  logic last1, last2, periodic, can_trig;

  pit_dec #(.W(W)) u_dec1 (.val_i(cnt_q), .bcd_i(bcd_q), .val_o(dec1));
  pit_dec #(.W(W)) u_dec2 (.val_i(dec1),  .bcd_i(bcd_q), .val_o(dec2));

  assign mode_new = decode_mode(mode_i);
  assign last1    = (cnt_q == ONE);
  assign last2    = (cnt_q == TWO);
  assign periodic = (mode_q == MD_RATE) || (mode_q == MD_SQUARE);
  assign can_trig = trig_q & loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MD_TC_IRQ;
      bcd_q     <= 1'b0;
      cnt_q     <= '0;
      reload_q  <= '0;
      out_q     <= 1'b0;
      loaded_q  <= 1'b0;
      st_pend_q <= 1'b0;
      run_q     <= 1'b0;
      trig_q    <= 1'b0;
      strobe_q  <= 1'b0;
    end else if (mode_wr_i) begin
      mode_q    <= mode_new;
      bcd_q     <= bcd_i;
      cnt_q     <= '0;
      out_q     <= (mode_new != MD_TC_IRQ);
      loaded_q  <= 1'b0;
      st_pend_q <= 1'b0;
      run_q     <= 1'b0;
      trig_q    <= 1'b0;
      strobe_q  <= 1'b0;
    end else begin
      trig_q <= gate_rise_i | (trig_q & ~tick_i);

      if (tick_i) begin
        if (strobe_q) begin
          out_q    <= 1'b1;
          strobe_q <= 1'b0;
        end
        case (mode_q)
          MD_TC_IRQ, MD_SW_STB: begin
            if (st_pend_q) begin
              cnt_q     <= reload_q;
              run_q     <= 1'b1;
              st_pend_q <= 1'b0;
            end else if (run_q && gate_i) begin
              cnt_q <= dec1;
              if (last1) begin
                run_q <= 1'b0;
                if (mode_q == MD_TC_IRQ) begin
                  out_q <= 1'b1;
                end else begin
                  out_q    <= 1'b0;
                  strobe_q <= 1'b1;
                end
              end
            end
          end
          MD_ONESHOT, MD_HW_STB: begin
            if (can_trig) begin
              cnt_q <= reload_q;
              run_q <= 1'b1;
              if (mode_q == MD_ONESHOT) out_q <= 1'b0;
            end else if (run_q) begin
              cnt_q <= dec1;
              if (last1) begin
                run_q <= 1'b0;
                if (mode_q == MD_ONESHOT) begin
                  out_q <= 1'b1;
                end else begin
                  out_q    <= 1'b0;
                  strobe_q <= 1'b1;
                end
              end
            end
          end
          default: begin
            if (gate_i) begin
              if (st_pend_q || can_trig) begin
                cnt_q     <= reload_q;
                out_q     <= 1'b1;
                run_q     <= 1'b1;
                st_pend_q <= 1'b0;
              end else if (run_q) begin
                if (mode_q == MD_RATE) begin
                  if (last1) begin
                    cnt_q <= reload_q;
                    out_q <= 1'b1;
                  end else begin
                    cnt_q <= dec1;
                    if (last2) out_q <= 1'b0;
                  end
                end else if (last1 || last2) begin
                  // odd N: low half reloads N-1
                  out_q <= ~out_q;
                  cnt_q <= out_q ? (reload_q & ~ONE) : reload_q;
                end else begin
                  cnt_q <= dec2;
                end
              end
            end
          end
        endcase
      end

      if (periodic && !gate_i) out_q <= 1'b1;

      if (load_i) begin
        reload_q <= count_i;
        loaded_q <= 1'b1;
        case (mode_q)
          MD_TC_IRQ: begin
            out_q     <= 1'b0;
            st_pend_q <= 1'b1;
            run_q     <= 1'b0;
          end
          MD_SW_STB: begin
            st_pend_q <= 1'b1;
            run_q     <= 1'b0;
          end
          MD_RATE, MD_SQUARE: begin
            if (!run_q) st_pend_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;
endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              gate_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              bcd_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              out_o
);
  logic gate_rise;

  pit_gate_edge u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (gate_rise)
  );

  pit_chan_ctrl #(.W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (cnt_en_i),
    .gate_i      (gate_i),
    .gate_rise_i (gate_rise),
    .mode_wr_i   (mode_wr_i),
    .mode_i      (mode_i),
    .bcd_i       (bcd_i),
    .load_i      (load_i),
    .count_i     (count_i),
    .cnt_o       (count_o),
    .out_o       (out_o)
  );
endmodule

// File: rtl/pit_chan_chk.sv
module pit_chan_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_en_i,
  input logic         gate_i,
  input logic         mode_wr_i,
  input logic [2:0]   mode_i,
  input logic         bcd_i,
  input logic         load_i,
  input logic [W-1:0] count_i,
  input logic [W-1:0] count_o,
  input logic         out_o
);
  logic [2:0] chk_mode;
  logic       chk_bcd;
  logic       bcd_ok;
  logic       chk_periodic, chk_gate_trig;
  logic       unused_in;

  assign unused_in = load_i ^ (^count_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_mode <= 3'd0;
      chk_bcd  <= 1'b0;
    end else if (mode_wr_i) begin
      chk_mode <= mode_i[1] ? {1'b0, mode_i[1:0]} : mode_i;
      chk_bcd  <= bcd_i;
    end
  end

  always_comb begin
    bcd_ok = 1'b1;
    for (int i = 0; i < W / 4; i++) begin
      if (count_o[4*i +: 4] > 4'd9) bcd_ok = 1'b0;
    end
  end

  assign chk_periodic  = (chk_mode == 3'd2) || (chk_mode == 3'd3);
  assign chk_gate_trig = (chk_mode == 3'd1) || (chk_mode == 3'd5);

  a_r11_mode0_out_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && (mode_i == 3'd0) |=> !out_o);

  a_r11_mode_out_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && (mode_i != 3'd0) |=> out_o);

  a_r10_gate_low_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_periodic && !gate_i && !mode_wr_i |=> out_o);

  a_r12_count_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i && !mode_wr_i |=> $stable(count_o));

  a_r12_trig_out_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_gate_trig && !cnt_en_i && !mode_wr_i |=> $stable(out_o));

  a_r8_bcd_digits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_bcd |-> (bcd_ok || unused_in === 1'bx));
endmodule

bind pit_chan pit_chan_chk #(.W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_en_i  (cnt_en_i),
  .gate_i    (gate_i),
  .mode_wr_i (mode_wr_i),
  .mode_i    (mode_i),
  .bcd_i     (bcd_i),
  .load_i    (load_i),
  .count_i   (count_i),
  .count_o   (count_o),
  .out_o     (out_o)
);

// File: tb/pit_chan_bench.sv
module pit_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  typedef struct packed {
    logic [2:0]  mode;
    logic        bcd;
    logic [15:0] n;
    logic [15:0] hi;
    logic [15:0] lo;
  } vec_t;

  // periodic modes: expected high/low tick counts per period
  localparam vec_t VEC [NV] = '{
    '{3'd2, 1'b0, 16'd5,     16'd4, 16'd1},
    '{3'd2, 1'b0, 16'd2,     16'd1, 16'd1},
    '{3'd3, 1'b0, 16'd8,     16'd4, 16'd4},
    '{3'd3, 1'b0, 16'd7,     16'd4, 16'd3},
    '{3'd3, 1'b0, 16'd3,     16'd2, 16'd1},
    '{3'd6, 1'b0, 16'd4,     16'd3, 16'd1},
    '{3'd7, 1'b0, 16'd5,     16'd3, 16'd2},
    '{3'd2, 1'b1, 16'h0012,  16'd11, 16'd1},
    '{3'd3, 1'b1, 16'h0011,  16'd6, 16'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        gate = 1'b1;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        bcd = 1'b0;
  logic        load = 1'b0;
  logic [15:0] count_in = 16'd0;
  logic [15:0] count_out;
  logic        out;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pit_chan u_pit_chan (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cnt_en_i  (cnt_en),
    .gate_i    (gate),
    .mode_wr_i (mode_wr),
    .mode_i    (mode),
    .bcd_i     (bcd),
    .load_i    (load),
    .count_i   (count_in),
    .count_o   (count_out),
    .out_o     (out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    cnt_en = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic hold(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic write_mode(input logic [2:0] m, input logic b);
    mode_wr = 1'b1; mode = m; bcd = b;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic load_cnt(input logic [15:0] n);
    load = 1'b1; count_in = n;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic gate_pulse();
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
  endtask

  task automatic measure(input logic lvl, output int c);
    c = 0;
    while (out === lvl && c < 70000) begin
      c++;
      step();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hi, lo, hi2;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out", out, 0);
    chk("R1 count", count_out, 0);

    // table of periodic-mode vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].mode >= 3'd6)      tag = "R11 alias";
      else if (VEC[i].bcd)          tag = "R8 bcd period";
      else if (VEC[i].mode == 3'd2) tag = "R4 rate";
      else                          tag = "R5 square";
      write_mode(VEC[i].mode, VEC[i].bcd);
      load_cnt(VEC[i].n);
      step();
      measure(1'b1, hi);
      measure(1'b0, lo);
      measure(1'b1, hi2);
      chk({tag, " high"}, hi, {16'd0, VEC[i].hi});
      chk({tag, " low"}, lo, {16'd0, VEC[i].lo});
      chk({tag, " high2"}, hi2, {16'd0, VEC[i].hi});
    end

    // R2 mode 0
    write_mode(3'd0, 1'b0);
    chk("R2 out after mode", out, 0);
    load_cnt(16'd4);
    step();
    chk("R2 loaded", count_out, 4);
    repeat (3) step();
    chk("R2 count before tc", count_out, 1);
    chk("R2 out before tc", out, 0);
    step();
    chk("R2 out at tc", out, 1);
    step();
    chk("R2 out holds", out, 1);

    // R10 gate suspends mode 0
    load_cnt(16'd3);
    chk("R2 out after reload", out, 0);
    step();
    gate = 1'b0;
    repeat (3) step();
    chk("R10 suspended count", count_out, 3);
    gate = 1'b1;
    repeat (2) step();
    chk("R10 resumed out", out, 0);
    step();
    chk("R10 resumed tc", out, 1);

    // R8 R9 BCD zero and decade borrow
    write_mode(3'd0, 1'b1);
    load_cnt(16'h0000);
    step();
    step();
    chk("R8 R9 bcd wrap", count_out, 16'h9999);
    hold(9998);
    chk("R9 bcd near end", count_out, 16'h0001);
    chk("R9 bcd out low", out, 0);
    step();
    chk("R9 bcd 10000 tc", out, 1);
    load_cnt(16'h1000);
    step();
    step();
    chk("R8 decade borrow", count_out, 16'h0999);

    // R6 mode 4
    write_mode(3'd4, 1'b0);
    load_cnt(16'd3);
    step();
    repeat (2) step();
    chk("R6 out before tc", out, 1);
    step();
    chk("R6 strobe low", out, 0);
    step();
    chk("R6 strobe end", out, 1);

    // R9 binary zero as 65536
    load_cnt(16'd0);
    step();
    hold(65535);
    chk("R9 bin near end", count_out, 1);
    chk("R9 bin out high", out, 1);
    step();
    chk("R9 bin 65536 tc", out, 0);
    step();
    chk("R9 bin strobe end", out, 1);

    // R3 mode 1 with retrigger
    write_mode(3'd1, 1'b0);
    load_cnt(16'd3);
    repeat (2) step();
    chk("R3 idle no trigger", out, 1);
    chk("R3 idle count", count_out, 0);
    gate_pulse();
    chk("R12 no tick count", count_out, 0);
    chk("R12 no tick out", out, 1);
    step();
    chk("R3 triggered out", out, 0);
    chk("R3 triggered count", count_out, 3);
    step();
    gate_pulse();
    step();
    chk("R3 retrigger count", count_out, 3);
    repeat (2) step();
    chk("R3 still low", out, 0);
    step();
    chk("R3 end high", out, 1);

    // R7 mode 5
    write_mode(3'd5, 1'b0);
    load_cnt(16'd2);
    step();
    chk("R7 idle count", count_out, 0);
    gate_pulse();
    step();
    chk("R7 started count", count_out, 2);
    step();
    chk("R7 out before tc", out, 1);
    step();
    chk("R7 strobe low", out, 0);
    step();
    chk("R7 strobe end", out, 1);

    // R10 mode 2 gate forcing and reload
    write_mode(3'd2, 1'b0);
    load_cnt(16'd5);
    step();
    repeat (4) step();
    chk("R4 low pulse", out, 0);
    chk("R4 low count", count_out, 1);
    gate = 1'b0;
    @(negedge clk);
    chk("R10 gate forces high", out, 1);
    step();
    chk("R10 hold count", count_out, 1);
    gate = 1'b1;
    @(negedge clk);
    step();
    chk("R10 gate reload", count_out, 5);

    // R11 mode write beats count write
    mode_wr = 1'b1; mode = 3'd4; bcd = 1'b0;
    load = 1'b1; count_in = 16'd7;
    @(negedge clk);
    mode_wr = 1'b0; load = 1'b0;
    repeat (2) step();
    chk("R11 load ignored count", count_out, 0);
    chk("R11 out high", out, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule